// File: doc/BRIEF.md
# Programmable Core / Bus / Peripheral Clock-Enable Chain

This block derives three single-cycle clock-enable strobes from one fast system clock. The enables are a core enable, a bus enable and a peripheral enable, all settings held in one 32-bit control word inside a small register window. The chain starts from one of two source tick inputs: a PLL-rate tick, or a bypass reference tick. An optional pulse-swallowing stage lets three of every four source ticks through. A core divider then issues one core enable per (1 + core field) surviving ticks. A bus divider issues one bus enable per (1 + bus field) core enables. A fixed halving stage issues one peripheral enable per two bus enables.

Software reaches the control word through a word-only request/response port. A request is taken when `req_valid` and `req_ready` are both high. A read returns its data one cycle later on `rsp_valid`/`rsp_rdata`, and that beat is held until `rsp_ready` is high. While a read response waits, `req_ready` stays low, so the requester must hold its request. Writes produce no response beat. A divide-field update is applied by each divider only when that divider wraps, so no enable period is ever cut short.

Top module: `core_clk_chain`

## Requirements
- R1: With control bit 22 set, the chain counts `ref_tick` pulses; with it clear, it counts `pll_tick` pulses.
- R2: With control bit 14 set, exactly three of every four selected source ticks reach the core divider; with it clear, all of them do.
- R3: `core_en` pulses once per (1 + N) ticks leaving the swallowing stage, where N is control bits [31:30].
- R4: `bus_en` pulses once per (1 + M) `core_en` pulses, where M is control bits [29:28], and only in a cycle where `core_en` is high.
- R5: `per_en` pulses once per two `bus_en` pulses, and only in a cycle where `bus_en` is high.
- R6: After a divide field is rewritten, every interval between successive pulses of that stage equals either the old period or the new period.
- R7: An aligned access at byte address below 0x70 selects word address >> 2. Word 0x08 is the control word. A read returns the last value written to that word, in the cycle after the read is accepted.
- R8: A read at byte address 0x70 or above returns 0, and a write there changes no register.
- R9: An access with address bits [1:0] not zero is rejected: a read returns 0 and a write changes no register.
- R10: After reset the control word reads 0xD0030000 and every other word reads 0. With the PLL source ticking every cycle, this gives core, bus and peripheral enables at 1/4, 1/8 and 1/16 of the cycle rate.
- R11: A rejected access (R8 or R9) sets a sticky error flag. A read of word 0x6C returns the flag in bit 0 and clears it. Writes to 0x6C are ignored.
- R12: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_tick | input | 1 | PLL-rate source tick |
| ref_tick | input | 1 | Bypass reference source tick |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Read data taken this cycle |
| rsp_rdata | output | 32 | Read data |
| core_en | output | 1 | Core clock enable strobe |
| bus_en | output | 1 | Bus clock enable strobe |
| per_en | output | 1 | Peripheral clock enable strobe |

## Verification
The bench builds the block with its default parameters: a 12-bit address, 28 words, the control word at index 2, reset value 0xD0030000 and a swallowing period of four. With only two bits per divide field, a seeded random sweep covers the whole space of divide settings, source choices and swallow settings. Every window of 2304 cycles then holds a whole number of chain periods, so pulse counts can be compared exactly. The 12-bit address also reaches well beyond the 0x70 window limit, which brings aliasing and out-of-range rejection within reach of the checks.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam int DIV_W        = 2;
  localparam int CORE_DIV_LSB = 30;
  localparam int BUS_DIV_LSB  = 28;
  localparam int BYPASS_BIT   = 22;
  localparam int DROP_BIT     = 14;

  typedef struct packed {
    logic [DIV_W-1:0] core_div;
    logic [DIV_W-1:0] bus_div;
    logic             bypass;
    logic             drop;
  } ctl_t;

  function automatic ctl_t decode_ctl(input logic [31:0] w);
    ctl_t c;
    c.core_div = w[CORE_DIV_LSB +: DIV_W];
    c.bus_div  = w[BUS_DIV_LSB +: DIV_W];
    c.bypass   = w[BYPASS_BIT];
    c.drop     = w[DROP_BIT];
    return c;
  endfunction
endpackage

// File: rtl/ccd_regbank.sv
module ccd_regbank #(
  parameter int          ADDR_W    = 12,
  parameter int          NUM_WORDS = 28,
  parameter int          CTL_IDX   = 2,
  parameter logic [31:0] CTL_RST   = 32'hD003_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic [31:0]       ctl_word
);
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int WIN_BYTES = NUM_WORDS * 4;
  localparam int ERR_IDX   = NUM_WORDS - 1;

  logic [31:0]      bank [NUM_WORDS];
  logic             err_q;
  logic             accept, in_win, aligned, ok;
  logic [IDX_W-1:0] idx;
  logic [31:0]      rd_val;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign in_win    = 32'(req_addr) < 32'(WIN_BYTES);
  assign aligned   = (req_addr[1:0] == 2'b00);
  assign ok        = in_win && aligned;
  assign idx       = req_addr[IDX_W+1:2];
  assign ctl_word  = bank[CTL_IDX];

  always_comb begin
    rd_val = '0;
    if (ok) begin
      if (32'(idx) == 32'(ERR_IDX)) rd_val = {31'b0, err_q};
      else                          rd_val = bank[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++)
        bank[i] <= (i == CTL_IDX) ? CTL_RST : 32'h0;
    end else if (accept && req_write && ok && (32'(idx) != 32'(ERR_IDX))) begin
      bank[idx] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (accept && !ok) begin
      err_q <= 1'b1;
    end else if (accept && !req_write && (32'(idx) == 32'(ERR_IDX))) begin
      err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ccd_rate_sel.sv
module ccd_rate_sel #(
  parameter int DROP_PERIOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_tick,
  input  logic ref_tick,
  input  logic bypass,
  input  logic drop,
  output logic tick_o
);
  localparam int CNT_W = (DROP_PERIOD > 1) ? $clog2(DROP_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DROP_PERIOD - 1);

  logic             src;
  logic [CNT_W-1:0] phase_q;

  assign src    = bypass ? ref_tick : pll_tick;
  assign tick_o = src && !(drop && (phase_q == LAST));

  always_ff @(posedge clk) begin
    if (!rst_n)           phase_q <= '0;
    else if (src)         phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/ccd_div.sv
module ccd_div #(
  parameter int             W       = 2,
  parameter logic [W-1:0]   RST_LIM = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q, cur_q;

  assign pulse_o = en_i && (cnt_q == cur_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cur_q <= RST_LIM;
    end else if (en_i) begin
      if (cnt_q == cur_q) begin
        cnt_q <= '0;
        cur_q <= lim_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/core_clk_chain.sv
module core_clk_chain
  import ccd_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          NUM_WORDS   = 28,
  parameter int          CTL_IDX     = 2,
  parameter logic [31:0] CTL_RST     = 32'hD003_0000,
  parameter int          DROP_PERIOD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_tick,
  input  logic              ref_tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              core_en,
  output logic              bus_en,
  output logic              per_en
);
  localparam int   STAGES  = 3;
  localparam ctl_t RST_CTL = decode_ctl(CTL_RST);

  logic [31:0]      ctl_word;
  ctl_t             ctl;
  logic [STAGES:0]  en_chain;
  logic [DIV_W-1:0] lim [STAGES];

  ccd_regbank #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .CTL_IDX(CTL_IDX), .CTL_RST(CTL_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ctl_word(ctl_word)
  );

  assign ctl = decode_ctl(ctl_word);

  ccd_rate_sel #(.DROP_PERIOD(DROP_PERIOD)) u_sel (
    .clk(clk), .rst_n(rst_n), .pll_tick(pll_tick), .ref_tick(ref_tick),
    .bypass(ctl.bypass), .drop(ctl.drop), .tick_o(en_chain[0])
  );

  always_comb begin
    lim[0] = ctl.core_div;
    lim[1] = ctl.bus_div;
    lim[2] = DIV_W'(1);
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    localparam logic [DIV_W-1:0] RL = (g == 0) ? RST_CTL.core_div :
                                      (g == 1) ? RST_CTL.bus_div : DIV_W'(1);
    ccd_div #(.W(DIV_W), .RST_LIM(RL)) u_div (
      .clk(clk), .rst_n(rst_n), .en_i(en_chain[g]), .lim_i(lim[g]),
      .pulse_o(en_chain[g+1])
    );
  end

  assign core_en = en_chain[1];
  assign bus_en  = en_chain[2];
  assign per_en  = en_chain[3];
endmodule

// File: rtl/core_clk_chain_chk.sv
module core_clk_chain_chk #(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pll_tick,
  input logic              ref_tick,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              core_en,
  input logic              bus_en,
  input logic              per_en
);
  localparam int WIN_BYTES = NUM_WORDS * 4;

  // R1: a core strobe needs a source tick in the same cycle
  p_core_needs_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> (pll_tick || ref_tick));

  // R4: bus strobe only alongside a core strobe
  p_bus_on_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> core_en);

  // R5: peripheral strobe only alongside a bus strobe
  p_per_on_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    per_en |-> bus_en);

  // R8: out-of-window read returns zero
  p_oob_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && (32'(req_addr) >= 32'(WIN_BYTES)))
    |=> (rsp_valid && rsp_rdata == 32'h0));

  // R9: misaligned read returns zero
  p_misalign_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && (req_addr[1:0] != 2'b00))
    |=> (rsp_valid && rsp_rdata == 32'h0));

  // R12: stalled response blocks new requests
  p_stall_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R12: stalled response is held unchanged
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind core_clk_chain core_clk_chain_chk #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_tick(pll_tick), .ref_tick(ref_tick),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .core_en(core_en), .bus_en(bus_en), .per_en(per_en)
);

// File: tb/core_clk_chain_tb.sv
module core_clk_chain_tb;
  localparam int AW  = 12;
  localparam int WIN = 2304;

  logic clk = 0, rst_n = 0;
  logic pll_tick = 1, ref_tick = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, core_en, bus_en, per_en;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_bad = 0;
  logic [31:0] shadow [27];

  core_clk_chain u_dut (
    .clk(clk), .rst_n(rst_n), .pll_tick(pll_tick), .ref_tick(ref_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .core_en(core_en), .bus_en(bus_en), .per_en(per_en)
  );

  always #2 clk = ~clk;

  initial forever begin
    @(posedge clk);
    #1 ref_tick = ~ref_tick;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  function automatic logic [31:0] mk_ctl(int n, int m, bit byp, bit sel);
    logic [31:0] w = 32'h0003_0000;
    w[31:30] = 2'(n); w[29:28] = 2'(m); w[22] = byp; w[14] = sel;
    return w;
  endfunction

  function automatic int exp_core(int n, bit byp, bit sel);
    int s = byp ? WIN / 2 : WIN;
    if (sel) s = s * 3 / 4;
    return s / (n + 1);
  endfunction

  task automatic measure(output int c, output int b, output int p);
    c = 0; b = 0; p = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      c += int'(core_en); b += int'(bus_en); p += int'(per_en);
    end
  endtask

  task automatic chain_check(input string tag, int n, int m, bit byp, bit sel);
    int c, b, p, ec;
    wr(12'h008, mk_ctl(n, m, byp, sel));
    repeat (400) @(negedge clk);
    measure(c, b, p);
    ec = exp_core(n, byp, sel);
    chk({tag, " core R3"}, c, ec);
    chk({tag, " bus R4"}, b, ec / (m + 1));
    chk({tag, " per R5"}, p, ec / (m + 1) / 2);
  endtask

  task automatic gap_check(input int n_old, input int n_new);
    int gap, bad, seen_new, prev;
    wr(12'h008, mk_ctl(n_old, 0, 0, 0));
    repeat (50 + $urandom_range(0, 3)) @(negedge clk);
    wr(12'h008, mk_ctl(n_new, 0, 0, 0));
    gap = 0; bad = 0; seen_new = 0; prev = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      gap++;
      if (core_en) begin
        if (prev) begin
          if (gap != n_old + 1 && gap != n_new + 1) bad++;
          if (gap == n_new + 1) seen_new = 1;
        end
        prev = 1; gap = 0;
      end
    end
    chk("R6 odd interval count", bad, 0);
    chk("R6 new period reached", seen_new, 1);
  endtask

  initial begin
    logic [31:0] d;
    int c, b, p;
    void'($urandom(32'h1A2B));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 reset values and reset rates
    rd(12'h008, d); chk("R10 ctl reset", d, 32'hD003_0000);
    rd(12'h000, d); chk("R10 word0 reset", d, 32'h0);
    rd(12'h06C, d); chk("R11 flag clear after reset", d, 32'h0);
    measure(c, b, p);
    chk("R10 core rate", c, WIN / 4);
    chk("R10 bus rate", b, WIN / 8);
    chk("R10 per rate", p, WIN / 16);

    // R7 read-back of written words
    wr(12'h000, 32'h1234_5678); rd(12'h000, d); chk("R7 word0", d, 32'h1234_5678);
    wr(12'h068, 32'hCAFE_F00D); rd(12'h068, d); chk("R7 last word", d, 32'hCAFE_F00D);

    // R9 misaligned write ignored, flag set then cleared
    wr(12'h00A, 32'h0); rd(12'h008, d); chk("R9 ctl untouched", d, 32'hD003_0000);
    rd(12'h001, d); chk("R9 misaligned read", d, 32'h0);
    rd(12'h06C, d); chk("R11 flag set", d, 32'h1);
    rd(12'h06C, d); chk("R11 flag cleared on read", d, 32'h0);
    wr(12'h06C, 32'hFFFF_FFFF); rd(12'h06C, d); chk("R11 write ignored", d, 32'h0);

    // R8 out-of-window accesses
    wr(12'h070, 32'h5555_5555); wr(12'h080, 32'hAAAA_AAAA); wr(12'hFFC, 32'h7777_7777);
    rd(12'h000, d); chk("R8 no alias word0", d, 32'h1234_5678);
    rd(12'h010, d); chk("R8 no alias word4", d, 32'h0);
    rd(12'h070, d); chk("R8 read zero", d, 32'h0);
    rd(12'h06C, d); chk("R11 flag after oob", d, 32'h1);

    // R12 back-pressure on the read response
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 12'h008;
    @(negedge clk);
    req_valid = 0;
    chk("R12 rsp valid", rsp_valid, 1);
    chk("R12 req blocked", req_ready, 0);
    repeat (3) @(negedge clk);
    chk("R12 data held", rsp_rdata, 32'hD003_0000);
    rsp_ready = 1;
    @(negedge clk);
    chk("R12 released", rsp_valid, 0);

    // R7 random bank traffic against a shadow copy
    for (int i = 0; i < 27; i++) shadow[i] = (i == 0) ? 32'h1234_5678 :
                                              (i == 26) ? 32'hCAFE_F00D :
                                              (i == 2) ? 32'hD003_0000 : 32'h0;
    for (int i = 0; i < 30; i++) begin
      int k = $urandom_range(0, 26);
      logic [31:0] v = $urandom;
      if (k == 2) k = 3;
      shadow[k] = v;
      wr(AW'(k * 4), v);
    end
    for (int i = 0; i < 27; i++) begin
      rd(AW'(i * 4), d); chk("R7 random readback", d, shadow[i]);
    end

    // R1 R2 R3 R4 R5 directed corners
    chain_check("div1 pll", 0, 0, 0, 0);
    chain_check("max div", 3, 3, 0, 0);
    chain_check("bypass R1", 1, 2, 1, 0);
    chain_check("drop R2", 2, 1, 0, 1);
    chain_check("bypass drop R2", 3, 3, 1, 1);

    // random configurations
    for (int i = 0; i < 8; i++)
      chain_check("random", $urandom_range(0, 3), $urandom_range(0, 3),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

    // R6 divide change applied only at wrap
    gap_check(3, 0);
    gap_check(0, 3);
    gap_check(1, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 180000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule